// File: doc/BRIEF.md
# Bytecode Integer Execute Unit

This block takes one 32-bit instruction word per cycle and carries it out in that same cycle against a private file of sixteen 32-bit registers. It handles the instructions that write a register: loading a 16-bit constant into one half of a register, copying, add and subtract with a folded-in 12-bit constant, bitwise logic, and shifts. Opcodes it does not implement raise a one-cycle illegal flag. The halt opcode stops the unit until the next reset.

The unit reports every register write on its write-back outputs one cycle after the instruction is accepted. A host can read any register by issuing a copy of that register onto itself and watching the write-back value. There are no other outputs.

Top module: `bcExecUnit`

## Requirements
- R1: While `rstN` is low and after it rises, `wbValid`, `illegalOp` and `halted` are 0, and every register holds zero.
- R2: Fields: opcode is bits 31:24, Rd bits 23:20, Ra or mode bits 19:16, Rb bits 15:12, the 12-bit constant bits 11:0 and the 16-bit constant bits 15:0. Opcode 16 puts the 16-bit constant in the upper half of Rd and opcode 17 puts it in the lower half. A mode of 4'b0000 zeroes the other half, 4'b1111 sets it to all ones and 4'b0001 leaves it as it was.
- R3: For opcodes 16 and 17, any other mode value leaves the other half as it was, still writes Rd, and raises `illegalOp`.
- R4: Opcode 18 writes the value of Ra into Rd.
- R5: Opcodes 32 (sign-extended constant) and 33 (zero-extended constant) write Ra + Rb + constant into Rd, modulo 2^32.
- R6: Opcodes 34 (sign-extended) and 35 (zero-extended) write Ra − Rb − constant into Rd, modulo 2^32.
- R7: Opcodes 64, 65 and 66 write Ra AND, OR and XOR Rb into Rd. Opcode 67 writes NOT Ra into Rd.
- R8: Opcodes 72 and 74 shift Ra left, 73 shifts it right and fills with its sign bit, and 75 shifts it right and fills with zeros. The shift amount is bits 4:0 of Rb.
- R9: Any opcode other than 0, 16–18, 32–35, 64–67 and 72–75 writes no register, leaves `wbValid` at 0 and raises `illegalOp` for one cycle.
- R10: Opcode 0 writes nothing, raises no illegal flag and sets `halted`. While `halted` is 1, every instruction is ignored until reset.
- R11: The instruction accepted at a rising edge with `instrValid` high appears on `wbValid`, `wbReg`, `wbData` and `illegalOp` right after that edge. With `instrValid` low, nothing is written and both flags stay 0.
- R12: An instruction that reads a register written by the instruction just before it sees the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 32 | Instruction word |
| wbValid | output | 1 | A register was written at the last edge |
| wbReg | output | 4 | Index of the register written |
| wbData | output | 32 | Value written |
| illegalOp | output | 1 | Last instruction was not a defined instruction or had a bad mode |
| halted | output | 1 | Halt opcode seen since reset |

## Verification
The hardest case to reach from the ports is the keep-mode half load, because its result depends on the old contents of the destination. Those contents change only through earlier instructions, and they can be seen only by copying the register out. The random stream mixes many half loads, including bad modes, into dense traffic on a few registers. The bench tracks a shadow register file, so every keep, shift amount and sign-extended constant is checked against the register values built up by that traffic. Directed cases then cover shift counts of 32 and above, sign fill on right shifts, wrap-around, and halt followed by reset.

// File: rtl/bcPkg.sv
package bcPkg;
  localparam int DATA_W  = 32;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 8;
  localparam int REG_AW  = 4;
  localparam int REG_CNT = 1 << REG_AW;
  localparam int IMM_W   = 12;
  localparam int HALF_W  = DATA_W / 2;
  localparam int SHAMT_W = $clog2(DATA_W);

  localparam logic [OPC_W-1:0] OPC_HALT  = 8'd0;
  localparam logic [OPC_W-1:0] OPC_SETHI = 8'd16;
  localparam logic [OPC_W-1:0] OPC_SETLO = 8'd17;
  localparam logic [OPC_W-1:0] OPC_COPY  = 8'd18;
  localparam logic [OPC_W-1:0] OPC_ADDS  = 8'd32;
  localparam logic [OPC_W-1:0] OPC_ADDU  = 8'd33;
  localparam logic [OPC_W-1:0] OPC_SUBS  = 8'd34;
  localparam logic [OPC_W-1:0] OPC_SUBU  = 8'd35;
  localparam logic [OPC_W-1:0] OPC_AND   = 8'd64;
  localparam logic [OPC_W-1:0] OPC_OR    = 8'd65;
  localparam logic [OPC_W-1:0] OPC_XOR   = 8'd66;
  localparam logic [OPC_W-1:0] OPC_NOT   = 8'd67;
  localparam logic [OPC_W-1:0] OPC_ASL   = 8'd72;
  localparam logic [OPC_W-1:0] OPC_ASR   = 8'd73;
  localparam logic [OPC_W-1:0] OPC_LSL   = 8'd74;
  localparam logic [OPC_W-1:0] OPC_LSR   = 8'd75;

  typedef enum logic [3:0] {
    ALU_SETHI, ALU_SETLO, ALU_COPY, ALU_ADD, ALU_SUB,
    ALU_AND, ALU_OR, ALU_XOR, ALU_NOT, ALU_SHL, ALU_ASR, ALU_LSR
  } aluSelE;

  typedef enum logic [1:0] {FILL_ZERO, FILL_ONES, FILL_KEEP} fillE;

  typedef struct packed {
    logic   writeEn;
    aluSelE aluSel;
    logic   signImm;
    fillE   fill;
    logic   illegal;
    logic   halt;
  } ctrlStrobesT;
endpackage

// File: rtl/bcControl.sv
module bcControl
  import bcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [REG_AW-1:0] modeField,
  output ctrlStrobesT       strobes,
  output logic              halted
);

  always_comb begin
    strobes.writeEn = 1'b0;
    strobes.aluSel  = ALU_COPY;
    strobes.signImm = 1'b0;
    strobes.fill    = FILL_KEEP;
    strobes.illegal = 1'b0;
    strobes.halt    = 1'b0;
    if (instrValid && !halted) begin
      case (opcode)
        OPC_HALT: strobes.halt = 1'b1;
        OPC_SETHI, OPC_SETLO: begin
          strobes.writeEn = 1'b1;
          strobes.aluSel  = (opcode == OPC_SETHI) ? ALU_SETHI : ALU_SETLO;
          case (modeField)
            4'b0000: strobes.fill = FILL_ZERO;
            4'b1111: strobes.fill = FILL_ONES;
            4'b0001: strobes.fill = FILL_KEEP;
            default: begin
              strobes.fill    = FILL_KEEP;
              strobes.illegal = 1'b1;
            end
          endcase
        end
        OPC_COPY: begin strobes.writeEn = 1'b1; strobes.aluSel = ALU_COPY; end
        OPC_ADDS, OPC_ADDU: begin
          strobes.writeEn = 1'b1;
          strobes.aluSel  = ALU_ADD;
          strobes.signImm = (opcode == OPC_ADDS);
        end
        OPC_SUBS, OPC_SUBU: begin
          strobes.writeEn = 1'b1;
          strobes.aluSel  = ALU_SUB;
          strobes.signImm = (opcode == OPC_SUBS);
        end
        OPC_AND: begin strobes.writeEn = 1'b1; strobes.aluSel = ALU_AND; end
        OPC_OR:  begin strobes.writeEn = 1'b1; strobes.aluSel = ALU_OR;  end
        OPC_XOR: begin strobes.writeEn = 1'b1; strobes.aluSel = ALU_XOR; end
        OPC_NOT: begin strobes.writeEn = 1'b1; strobes.aluSel = ALU_NOT; end
        OPC_ASL, OPC_LSL: begin strobes.writeEn = 1'b1; strobes.aluSel = ALU_SHL; end
        OPC_ASR: begin strobes.writeEn = 1'b1; strobes.aluSel = ALU_ASR; end
        OPC_LSR: begin strobes.writeEn = 1'b1; strobes.aluSel = ALU_LSR; end
        default: strobes.illegal = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             halted <= 1'b0;
    else if (strobes.halt) halted <= 1'b1;
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted); // R10

endmodule

// File: rtl/bcDatapath.sv
module bcDatapath
  import bcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [REG_AW-1:0] rdIdx,
  input  logic [REG_AW-1:0] raIdx,
  input  logic [REG_AW-1:0] rbIdx,
  input  logic [IMM_W-1:0]  imm12,
  input  logic [HALF_W-1:0] imm16,
  output logic              wbValid,
  output logic [REG_AW-1:0] wbReg,
  output logic [DATA_W-1:0] wbData,
  output logic              illegalOp
);

  localparam int IMM_PAD = DATA_W - IMM_W;

  logic [DATA_W-1:0] regFile [REG_CNT];
  logic [DATA_W-1:0] raVal, rbVal, rdOld, immExt, result;
  logic [HALF_W-1:0] fillHalf;
  logic [SHAMT_W-1:0] shAmt;

  assign raVal  = regFile[raIdx];
  assign rbVal  = regFile[rbIdx];
  assign rdOld  = regFile[rdIdx];
  assign shAmt  = rbVal[SHAMT_W-1:0];
  assign immExt = strobes.signImm ? {{IMM_PAD{imm12[IMM_W-1]}}, imm12}
                                  : {{IMM_PAD{1'b0}}, imm12};

  always_comb begin
    case (strobes.fill)
      FILL_ZERO: fillHalf = '0;
      FILL_ONES: fillHalf = '1;
      default:   fillHalf = (strobes.aluSel == ALU_SETHI) ? rdOld[HALF_W-1:0]
                                                          : rdOld[DATA_W-1:HALF_W];
    endcase
  end

  always_comb begin
    case (strobes.aluSel)
      ALU_SETHI: result = {imm16, fillHalf};
      ALU_SETLO: result = {fillHalf, imm16};
      ALU_COPY:  result = raVal;
      ALU_ADD:   result = raVal + rbVal + immExt;
      ALU_SUB:   result = raVal - rbVal - immExt;
      ALU_AND:   result = raVal & rbVal;
      ALU_OR:    result = raVal | rbVal;
      ALU_XOR:   result = raVal ^ rbVal;
      ALU_NOT:   result = ~raVal;
      ALU_SHL:   result = raVal << shAmt;
      ALU_ASR:   result = $unsigned($signed(raVal) >>> shAmt);
      ALU_LSR:   result = raVal >> shAmt;
      default:   result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) regFile[i] <= '0;
      wbValid   <= 1'b0;
      wbReg     <= '0;
      wbData    <= '0;
      illegalOp <= 1'b0;
    end else begin
      wbValid   <= strobes.writeEn;
      illegalOp <= strobes.illegal;
      if (strobes.writeEn) begin
        regFile[rdIdx] <= result;
        wbReg          <= rdIdx;
        wbData         <= result;
      end
    end
  end

  AST_WB_IN_FILE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (regFile[wbReg] == wbData)); // R11

endmodule

// File: rtl/bcExecUnit.sv
module bcExecUnit
  import bcPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output logic               wbValid,
  output logic [REG_AW-1:0]  wbReg,
  output logic [DATA_W-1:0]  wbData,
  output logic               illegalOp,
  output logic               halted
);

  ctrlStrobesT strobes;

  bcControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .opcode     (instrWord[31:24]),
    .modeField  (instrWord[19:16]),
    .strobes    (strobes),
    .halted     (halted)
  );

  bcDatapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rdIdx     (instrWord[23:20]),
    .raIdx     (instrWord[19:16]),
    .rbIdx     (instrWord[15:12]),
    .imm12     (instrWord[11:0]),
    .imm16     (instrWord[15:0]),
    .wbValid   (wbValid),
    .wbReg     (wbReg),
    .wbData    (wbData),
    .illegalOp (illegalOp)
  );

  AST_HALT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    $past(halted) |-> (!wbValid && !illegalOp)); // R10

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> (!wbValid && !illegalOp)); // R10

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(instrValid) |-> (!wbValid && !illegalOp)); // R11

endmodule

// File: tb/tb_bcExecUnit.sv
`timescale 1ns/1ps
module tb_bcExecUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        wbValid, illegalOp, halted;
  logic [3:0]  wbReg;
  logic [31:0] wbData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] mReg [16];
  bit          mHalted;

  always #2.5 clk = ~clk;

  bcExecUnit dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData),
    .illegalOp(illegalOp), .halted(halted)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int opc, input int rd, input int ra, input int rb, input int imm);
    return {8'(opc), 4'(rd), 4'(ra), 4'(rb), 12'(imm)};
  endfunction

  function automatic logic [31:0] mkC(input int opc, input int rd, input int mode, input int c16);
    return {8'(opc), 4'(rd), 4'(mode), 16'(c16)};
  endfunction

  // Expected result of one instruction from the requirements; updates the shadow state.
  task automatic predict(input logic [31:0] w, output logic eV, output logic [3:0] eR,
                         output logic [31:0] eD, output logic eI);
    int op;
    logic [3:0] rd, ra, rb, md;
    logic [31:0] a, b, ci, o;
    logic [15:0] oth;
    op = int'(w[31:24]); rd = w[23:20]; ra = w[19:16]; rb = w[15:12]; md = w[19:16];
    a = mReg[ra]; b = mReg[rb]; o = mReg[rd];
    eV = 1'b0; eR = rd; eD = '0; eI = 1'b0;
    if (mHalted) return;
    ci = (op == 32 || op == 34) ? {{20{w[11]}}, w[11:0]} : {20'd0, w[11:0]};
    eV = 1'b1;
    case (op)
      0: begin eV = 1'b0; mHalted = 1; end
      16, 17: begin
        if (md == 4'h0) oth = 16'h0000;
        else if (md == 4'hF) oth = 16'hFFFF;
        else begin
          oth = (op == 16) ? o[15:0] : o[31:16];
          eI = (md != 4'h1);
        end
        eD = (op == 16) ? {w[15:0], oth} : {oth, w[15:0]};
      end
      18: eD = a;
      32, 33: eD = a + b + ci;
      34, 35: eD = a - b - ci;
      64: eD = a & b;
      65: eD = a | b;
      66: eD = a ^ b;
      67: eD = ~a;
      72, 74: eD = a << b[4:0];
      73: begin
        eD = a >> b[4:0];
        if (a[31]) for (int k = 0; k < 32; k++) if (k >= 32 - int'(b[4:0])) eD[k] = 1'b1;
      end
      75: eD = a >> b[4:0];
      default: begin eV = 1'b0; eI = 1'b1; end
    endcase
    if (eV) mReg[rd] = eD;
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic issue(input logic [31:0] w, input string req);
    logic eV, eI;
    logic [3:0] eR;
    logic [31:0] eD;
    predict(w, eV, eR, eD, eI);
    instrValid = 1'b1;
    instrWord  = w;
    @(negedge clk);
    chk({req, " wbValid"}, 32'(wbValid), 32'(eV));
    chk({req, " illegalOp"}, 32'(illegalOp), 32'(eI));
    if (eV) begin
      chk({req, " wbReg"}, 32'(wbReg), 32'(eR));
      chk({req, " wbData"}, wbData, eD);
    end
  endtask

  task automatic readReg(input int r, input logic [31:0] exp, input string req);
    instrValid = 1'b1;
    instrWord  = mk(18, r, r, 0, 0);
    @(negedge clk);
    chk({req, " readback"}, wbData, exp);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    instrValid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset wbValid", 32'(wbValid), 0);
    chk("R1 reset illegalOp", 32'(illegalOp), 0);
    chk("R1 reset halted", 32'(halted), 0);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) mReg[i] = '0;
    mHalted = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  int legal [16] = '{16, 17, 18, 32, 33, 34, 35, 64, 65, 66, 67, 72, 73, 74, 75, 18};

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    @(negedge clk);
    doReset();
    // R1: registers hold zero
    readReg(5, 32'h0, "R1");
    readReg(15, 32'h0, "R1");

    // R2: half loads with the three modes
    issue(mkC(16, 1, 0, 16'h00A0), "R2");
    chk("R2 sethi clear", wbData, 32'h00A0_0000);
    issue(mkC(17, 1, 1, 16'h5600), "R2");
    chk("R2 setlo keep", wbData, 32'h00A0_5600);
    issue(mkC(17, 2, 15, 16'h1234), "R2");
    chk("R2 setlo ones", wbData, 32'hFFFF_1234);
    // R3: bad mode keeps other half and flags
    issue(mkC(16, 2, 3, 16'hBEEF), "R3");
    chk("R3 bad mode data", wbData, 32'hBEEF_1234);
    chk("R3 bad mode flag", 32'(illegalOp), 1);
    // R12: back-to-back dependency, R4 copy
    issue(mk(18, 3, 2, 0, 0), "R4");
    issue(mk(18, 4, 3, 0, 0), "R12");
    chk("R12 dependent copy", wbData, 32'hBEEF_1234);
    // R5 constant extension
    issue(mk(32, 5, 1, 0, 12'hFFF), "R5");
    chk("R5 add.s minus one", wbData, 32'h00A0_55FF);
    issue(mk(33, 6, 1, 0, 12'hFFF), "R5");
    chk("R5 add.u plus 4095", wbData, 32'h00A0_65FF);
    // R6 wrap
    issue(mkC(17, 7, 0, 1), "R6");
    issue(mk(35, 8, 0, 7, 0), "R6");
    chk("R6 sub wrap", wbData, 32'hFFFF_FFFF);
    issue(mk(34, 8, 0, 0, 12'hFFF), "R6");
    chk("R6 sub.s minus minus one", wbData, 32'h0000_0001);
    // R7
    issue(mk(67, 9, 2, 0, 0), "R7");
    chk("R7 not", wbData, 32'h4110_EDCB);
    issue(mk(66, 9, 2, 1, 0), "R7");
    // R8 shifts: amount 33 -> 1, sign fill
    issue(mkC(17, 10, 0, 33), "R8");
    issue(mk(73, 11, 2, 10, 0), "R8");
    chk("R8 asr sign fill", wbData, 32'hDF77_891A);
    issue(mk(75, 11, 2, 10, 0), "R8");
    chk("R8 lsr zero fill", wbData, 32'h5F77_891A);
    issue(mk(72, 11, 2, 10, 0), "R8");
    issue(mk(74, 11, 2, 10, 0), "R8");
    // R9 illegal opcodes, register untouched
    issue(mk(19, 1, 0, 0, 0), "R9");
    issue(mk(200, 1, 0, 0, 0), "R9");
    issue(mk(48, 1, 0, 0, 0), "R9");
    readReg(1, 32'h00A0_5600, "R9");
    // R11 idle cycle has no effect
    instrValid = 1'b0;
    instrWord  = mkC(16, 1, 0, 16'hDEAD);
    @(negedge clk);
    chk("R11 idle wbValid", 32'(wbValid), 0);
    chk("R11 idle illegalOp", 32'(illegalOp), 0);
    readReg(1, 32'h00A0_5600, "R11");

    // Random stream on all legal forms plus undefined opcodes
    for (int n = 0; n < 4000; n++) begin
      int sel, op;
      logic [31:0] w;
      sel = int'($urandom_range(0, 19));
      if (sel < 16) op = legal[sel];
      else begin
        op = int'($urandom_range(1, 255));
      end
      w = $urandom;
      w[31:24] = 8'(op);
      if ((op == 16 || op == 17) && $urandom_range(0, 3) != 0)
        w[19:16] = ($urandom_range(0, 1) == 1) ? 4'h1 : (($urandom_range(0, 1) == 1) ? 4'h0 : 4'hF);
      issue(w, "R2_R9 random");
    end

    // R10 halt
    issue(mk(0, 0, 0, 0, 0), "R10");
    chk("R10 halted set", 32'(halted), 1);
    issue(mkC(16, 1, 0, 16'h7777), "R10");
    issue(mk(200, 1, 0, 0, 0), "R10");
    chk("R10 still halted", 32'(halted), 1);
    doReset();
    chk("R10 cleared by reset", 32'(halted), 0);
    readReg(1, 32'h0, "R1");

    instrValid = 1'b0;
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule